// File: doc/BRIEF.md
# IrDA Pulse Shim

This block sits between the serial bit stream of a UART and an infrared transceiver. On the transmit side it watches the UART output at each bit boundary. A zero bit becomes one short active-high light pulse whose length can be programmed. A one bit leaves the emitter dark. On the receive side it takes the transceiver output, which can be set to either polarity, optionally rejects short glitches with a programmable minimum-length filter, and rebuilds a UART-level bit stream. A received pulse that is accepted drives the decoded line low until one bit period has passed since the pulse's leading edge.

Pulse and filter lengths are counted in timebase ticks. The timebase is every cycle of the block clock, which is the baud source clock. A 16x oversampling strobe is used instead only when that source is selected and oversampling mode is active. A single enable switches the whole shim in or out. When it is off, both bit streams pass straight through and both state machines are held in their idle states.

The encoder has two states, TX_IDLE and TX_PULSE:
- TX_IDLE -> TX_PULSE on a zero bit start.
- TX_PULSE -> TX_PULSE (restart) on another zero bit start.
- TX_PULSE -> TX_IDLE when the width count ends.

The decoder has three states, RX_WAIT, RX_QUAL and RX_HOLD:
- RX_WAIT -> RX_HOLD on a leading edge when the filter is off.
- RX_WAIT -> RX_QUAL on a leading edge when the filter is on.
- RX_QUAL -> RX_HOLD when the filter count is met.
- RX_QUAL -> RX_WAIT when the level drops or the bit period runs out.
- RX_HOLD -> RX_WAIT when the bit period ends.

When the enable is low, every state goes to its idle state.

Top module: `irda_shim`

## Requirements
- R1: With `ir_en` low, `ir_tx_out` equals `tx_bit` and `rx_bit` equals `ir_rx_in` in the same cycle, and neither state machine leaves its idle state.
- R2: With `ir_en` high, a `bit_start` strobe with `tx_bit`=0 drives `ir_tx_out` high from the next cycle for (`tx_pulse_len`+1)*2 timebase ticks. A strobe with `tx_bit`=1 produces no pulse. `tx_pulse_len` is held stable while a pulse is running.
- R3: The timebase ticks on `os_tick` only when both `pclk_sel` and `os_mode` are 1. In every other combination it ticks on every clock cycle.
- R4: With `rx_low_pol`=0 a light pulse is a high level on `ir_rx_in`. With `rx_low_pol`=1 it is a low level.
- R5: With the filter off (`rx_filt_en`=0 or `rx_filt_len`=0), a leading edge sampled at a clock edge drives `rx_bit` low from the next cycle for exactly `bit_cycles` cycles.
- R6: With the filter on, a pulse is accepted only if the active level is still sampled at each of the next `rx_filt_len`*2 timebase ticks after the leading-edge sample. A shorter pulse leaves `rx_bit` high.
- R7: An accepted filtered pulse drives `rx_bit` low from the cycle after acceptance. `rx_bit` returns high `bit_cycles` cycles after the leading edge. If the bit period expires first, the pulse is dropped.
- R8: A zero-bit strobe that arrives while a pulse is still running restarts the full pulse width.
- R9: After reset with `ir_en` high and no stimulus, `ir_tx_out` is 0 and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, the baud source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_en | input | 1 | Encoder/decoder enable; 0 means pass-through |
| os_mode | input | 1 | Oversampling mode active |
| pclk_sel | input | 1 | Pulse timebase select: 1 selects the 16x strobe |
| os_tick | input | 1 | 16x bit clock strobe, one cycle wide |
| bit_start | input | 1 | Strobe at the first cycle of each transmit bit |
| tx_bit | input | 1 | UART transmit bit |
| tx_pulse_len | input | 6 | Transmit pulse length code |
| ir_tx_out | output | 1 | Emitter drive, active high |
| ir_rx_in | input | 1 | Transceiver receive output |
| rx_low_pol | input | 1 | 1: light shows as a low level |
| rx_filt_en | input | 1 | Receive glitch filter enable |
| rx_filt_len | input | 6 | Receive filter length code |
| bit_cycles | input | 12 | Bit period in clock cycles, at least 2 |
| rx_bit | output | 1 | Decoded UART receive bit |

## Verification
Some rules are checked by assertions on every cycle:
- a zero-bit strobe always lands in TX_PULSE with a cleared count;
- the pulse count never passes the programmed width;
- the hold never outlives the bit period;
- a dropped level in RX_QUAL always returns the decoder to RX_WAIT;
- an unfiltered leading edge goes straight to RX_HOLD;
- a low enable parks the encoder.

Other behaviour needs the bench's scenarios, with a behavioural model compared every clock:
- the exact pulse widths under both timebases;
- restart on back-to-back zeros;
- rejection and acceptance around the filter threshold under both polarities;
- the pass-through levels.

// File: rtl/irda_pkg.sv
package irda_pkg;
    typedef enum logic {
        TX_IDLE,
        TX_PULSE
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_WAIT,
        RX_QUAL,
        RX_HOLD
    } rx_state_t;
endpackage

// File: rtl/irda_timebase.sv
module irda_timebase (
    input  logic os_mode,
    input  logic pclk_sel,
    input  logic os_tick,
    output logic tick
);
    // The 16x strobe only counts when oversampling is really running.
    logic use_os;
    assign use_os = pclk_sel & os_mode;
    assign tick   = use_os ? os_tick : 1'b1;
endmodule

// File: rtl/irda_tx_enc.sv
module irda_tx_enc
    import irda_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             bit_start,
    input  logic             tx_bit,
    input  logic [LEN_W-1:0] len,
    output logic             pulse
);
    localparam int CNT_W = LEN_W + 1;

    tx_state_t        state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             go;

    // (len+1)*2 ticks, so the final count index is 2*len+1.
    assign last = {len, 1'b1};
    assign go   = en & bit_start & ~tx_bit;

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:  if (go) state_nx = TX_PULSE;
            TX_PULSE: begin
                if (go)                        state_nx = TX_PULSE;
                else if (tick && cnt >= last)  state_nx = TX_IDLE;
            end
            default:  state_nx = TX_IDLE;
        endcase
        if (!en) state_nx = TX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (go)
                cnt <= '0;
            else if (state == TX_PULSE && tick)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        pulse = (state == TX_PULSE);
    end

    // R2
    tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (state == TX_PULSE && cnt == '0));

    // R2
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_PULSE) |-> (cnt <= last));

    // R1
    tx_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == TX_IDLE));
endmodule

// File: rtl/irda_rx_dec.sv
module irda_rx_dec
    import irda_pkg::*;
#(
    parameter int LEN_W = 6,
    parameter int BIT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             act,
    input  logic             filt_en,
    input  logic [LEN_W-1:0] filt_len,
    input  logic [BIT_W-1:0] bit_cycles,
    output logic             dec
);
    localparam int FC_W = LEN_W + 1;

    rx_state_t        state, state_nx;
    logic             act_d;
    logic             lead;
    logic             need_q;
    logic [FC_W-1:0]  fc;
    logic [FC_W-1:0]  fc_nx;
    logic [FC_W-1:0]  flim;
    logic [BIT_W-1:0] el;
    logic             period_end;

    assign lead       = act & ~act_d;
    assign need_q     = filt_en & (filt_len != '0);
    assign flim       = {filt_len, 1'b0};
    assign fc_nx      = fc + 1'b1;
    assign period_end = (el == bit_cycles);

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_WAIT: begin
                if (lead) state_nx = need_q ? RX_QUAL : RX_HOLD;
            end
            RX_QUAL: begin
                if (period_end || !act)       state_nx = RX_WAIT;
                else if (tick && fc_nx == flim) state_nx = RX_HOLD;
            end
            RX_HOLD: begin
                if (period_end) state_nx = RX_WAIT;
            end
            default: state_nx = RX_WAIT;
        endcase
        if (!en) state_nx = RX_WAIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_WAIT;
            act_d <= 1'b0;
            fc    <= '0;
            el    <= '0;
        end else begin
            state <= state_nx;
            act_d <= act;
            if (state == RX_WAIT) begin
                fc <= '0;
                el <= {{(BIT_W-1){1'b0}}, 1'b1};
            end else begin
                el <= el + 1'b1;
                if (tick) fc <= fc_nx;
            end
        end
    end

    always_comb begin
        dec = (state != RX_HOLD);
    end

    // R7
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HOLD) |-> (el <= bit_cycles));

    // R5
    rx_nofilt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_WAIT && en && lead && !need_q) |=> (state == RX_HOLD));

    // R6
    rx_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_QUAL && !act) |=> (state == RX_WAIT));
endmodule

// File: rtl/irda_shim.sv
module irda_shim #(
    parameter int LEN_W = 6,
    parameter int BIT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_en,
    input  logic             os_mode,
    input  logic             pclk_sel,
    input  logic             os_tick,
    input  logic             bit_start,
    input  logic             tx_bit,
    input  logic [LEN_W-1:0] tx_pulse_len,
    output logic             ir_tx_out,
    input  logic             ir_rx_in,
    input  logic             rx_low_pol,
    input  logic             rx_filt_en,
    input  logic [LEN_W-1:0] rx_filt_len,
    input  logic [BIT_W-1:0] bit_cycles,
    output logic             rx_bit
);
    logic tick;
    logic pulse;
    logic dec;
    logic light;

    assign light = ir_rx_in ^ rx_low_pol;

    irda_timebase u_tb (
        .os_mode (os_mode),
        .pclk_sel(pclk_sel),
        .os_tick (os_tick),
        .tick    (tick)
    );

    irda_tx_enc #(.LEN_W(LEN_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ir_en),
        .tick     (tick),
        .bit_start(bit_start),
        .tx_bit   (tx_bit),
        .len      (tx_pulse_len),
        .pulse    (pulse)
    );

    irda_rx_dec #(.LEN_W(LEN_W), .BIT_W(BIT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ir_en),
        .tick      (tick),
        .act       (light),
        .filt_en   (rx_filt_en),
        .filt_len  (rx_filt_len),
        .bit_cycles(bit_cycles),
        .dec       (dec)
    );

    assign ir_tx_out = ir_en ? pulse : tx_bit;
    assign rx_bit    = ir_en ? dec   : ir_rx_in;
endmodule

// File: tb/sim_irda_shim.sv
module sim_irda_shim;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_en = 1'b0;
    logic        os_mode = 1'b0;
    logic        pclk_sel = 1'b0;
    logic        os_tick = 1'b0;
    logic        bit_start = 1'b0;
    logic        tx_bit = 1'b1;
    logic [5:0]  tx_pulse_len = 6'd3;
    logic        ir_rx_in = 1'b0;
    logic        rx_low_pol = 1'b0;
    logic        rx_filt_en = 1'b0;
    logic [5:0]  rx_filt_len = 6'd0;
    logic [11:0] bit_cycles = 12'd16;
    logic        ir_tx_out;
    logic        rx_bit;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R9";

    // behavioural reference state
    int tx_rem = 0;
    int rx_mode = 0;   // 0 waiting, 1 qualifying, 2 holding low
    int rx_fc = 0;
    int rx_el = 0;
    bit act_prev = 0;

    always #5 clk = ~clk;

    irda_shim u0 (
        .clk(clk), .rst_n(rst_n), .ir_en(ir_en), .os_mode(os_mode),
        .pclk_sel(pclk_sel), .os_tick(os_tick), .bit_start(bit_start),
        .tx_bit(tx_bit), .tx_pulse_len(tx_pulse_len), .ir_tx_out(ir_tx_out),
        .ir_rx_in(ir_rx_in), .rx_low_pol(rx_low_pol), .rx_filt_en(rx_filt_en),
        .rx_filt_len(rx_filt_len), .bit_cycles(bit_cycles), .rx_bit(rx_bit)
    );

    // 16x strobe: one cycle in three
    int os_div = 0;
    always @(negedge clk) begin
        os_div  <= (os_div == 2) ? 0 : os_div + 1;
        os_tick <= (os_div == 2);
    end

    always @(posedge clk) begin
        bit tk, act, lead;
        if (!rst_n) begin
            tx_rem = 0; rx_mode = 0; rx_fc = 0; rx_el = 0; act_prev = 0;
        end else begin
            tk   = (pclk_sel && os_mode) ? os_tick : 1'b1;  // R3
            act  = ir_rx_in ^ rx_low_pol;                   // R4
            lead = act && !act_prev;
            if (!ir_en) tx_rem = 0;
            else if (bit_start && !tx_bit) tx_rem = 2 * (int'(tx_pulse_len) + 1);
            else if (tx_rem > 0 && tk) tx_rem = tx_rem - 1;
            if (!ir_en) rx_mode = 0;
            else if (rx_mode == 0) begin
                if (lead) begin
                    rx_el = 1; rx_fc = 0;
                    rx_mode = (rx_filt_en && rx_filt_len != 0) ? 1 : 2;
                end
            end else if (rx_mode == 1) begin
                if (rx_el == int'(bit_cycles) || !act) rx_mode = 0;
                else if (tk) begin
                    rx_fc = rx_fc + 1;
                    if (rx_fc == 2 * int'(rx_filt_len)) rx_mode = 2;
                end
                rx_el = rx_el + 1;
            end else begin
                if (rx_el == int'(bit_cycles)) rx_mode = 0;
                rx_el = rx_el + 1;
            end
            act_prev = act;
        end
    end

    task automatic chk(string what, logic got, logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0b exp=%0b t=%0t", cur_req, what, got, exp, $time);
        end
    endtask

    // compare every clock, 1 ns before the falling edge
    always begin
        @(posedge clk);
        #4;
        if (rst_n && !done) begin
            chk("ir_tx_out", ir_tx_out, ir_en ? (tx_rem > 0) : tx_bit);
            chk("rx_bit", rx_bit, ir_en ? (rx_mode != 2) : ir_rx_in);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b, int period);
        @(negedge clk);
        bit_start = 1'b1; tx_bit = b;
        @(negedge clk);
        bit_start = 1'b0;
        cyc(period - 2);
    endtask

    task automatic rx_pulse(int len, int gap);
        @(negedge clk);
        ir_rx_in = ~rx_low_pol;
        cyc(len);
        ir_rx_in = rx_low_pol;
        cyc(gap);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        ir_en = 1'b1;
        cyc(2);
        // R9: idle levels after reset
        cur_req = "R9";
        chk("reset ir_tx_out", ir_tx_out, 1'b0);
        chk("reset rx_bit", rx_bit, 1'b1);
        cyc(4);

        // R1: pass-through
        cur_req = "R1";
        ir_en = 1'b0;
        send_bit(1'b0, 6); send_bit(1'b1, 6);
        ir_rx_in = 1'b1; cyc(3); ir_rx_in = 1'b0; cyc(3);
        ir_en = 1'b1; tx_bit = 1'b1; cyc(4);

        // R2: pulses on zeros, none on ones, clock timebase
        cur_req = "R2";
        tx_pulse_len = 6'd3;
        send_bit(1'b0, 16); send_bit(1'b1, 16);
        send_bit(1'b0, 16); send_bit(1'b0, 16);
        tx_pulse_len = 6'd0;
        send_bit(1'b0, 16); send_bit(1'b1, 16);
        cyc(4);

        // R8: restart while a pulse runs
        cur_req = "R8";
        tx_pulse_len = 6'd3;
        send_bit(1'b0, 5); send_bit(1'b0, 5); send_bit(1'b1, 20);

        // R3: 16x strobe timebase, then selected without oversampling
        cur_req = "R3";
        pclk_sel = 1'b1; os_mode = 1'b1; tx_pulse_len = 6'd1;
        send_bit(1'b0, 20); send_bit(1'b1, 20);
        os_mode = 1'b0;
        send_bit(1'b0, 20);
        pclk_sel = 1'b0; cyc(4);

        // R5: unfiltered receive, active-high
        cur_req = "R5";
        rx_pulse(3, 25); rx_pulse(1, 25);

        // R4: active-low receive input
        cur_req = "R4";
        rx_low_pol = 1'b1; ir_rx_in = 1'b1; cyc(3);
        rx_pulse(3, 25);
        rx_low_pol = 1'b0; ir_rx_in = 1'b0; cyc(3);

        // R6: filter rejects short, accepts long
        cur_req = "R6";
        rx_filt_en = 1'b1; rx_filt_len = 6'd2;
        rx_pulse(3, 25); rx_pulse(4, 25); rx_pulse(5, 25); rx_pulse(8, 25);
        rx_filt_len = 6'd0;
        rx_pulse(2, 25);

        // R7: filtered acceptance ends on the bit period; timeout drop
        cur_req = "R7";
        rx_filt_len = 6'd3;
        rx_pulse(9, 25);
        pclk_sel = 1'b1; os_mode = 1'b1; rx_filt_len = 6'd2;
        rx_pulse(14, 25);
        rx_filt_len = 6'd6;
        rx_pulse(30, 25);
        pclk_sel = 1'b0; os_mode = 1'b0; rx_filt_en = 1'b0;
        cyc(5);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule